// File: doc/BRIEF.md
# Byte/Word Address Region Decoder

This block sits between a 16-bit little-endian CPU data port and the memories and peripherals that share one 64 KB address space used for both code and data. Every request names a byte address, a width (byte or word), a direction and write data. The block works out which of five regions the address falls in and raises that region's select. The regions are control bytes, narrow (8-bit) peripherals, wide (16-bit) peripherals, RAM and nonvolatile memory. It drives byte-lane enables and lane-steered write data to the selected target. One cycle later it returns the target's read data, formatted to the width of the request.

Width mismatches follow a fixed rule in each region. Control bytes accept only byte accesses. A narrow peripheral is written on its low lane only, so the high byte of a word write is dropped. When a narrow peripheral is read as a word, the upper byte comes back as a fixed fill value. A wide peripheral accepts bytes only at even addresses, and a byte read from it returns zero in the high byte. A word access at an odd address is illegal, and so is any of the illegal cases above. An illegal access raises an error strobe in the same cycle and reaches no target.

Top module: `bus_region_decoder`

## Requirements
- R1: With the default map, the regions are: control bytes 0000h–000Fh (rgn_sel bit 0), narrow peripherals 0010h–00FFh (bit 1), wide peripherals 0100h–01FFh (bit 2), RAM 0200h–09FFh (bit 3), nonvolatile memory 1100h–FFFFh (bit 4). At most one select is high, and only while req_valid is high.
- R2: A valid access to an unmapped address (0A00h–10FFh by default) raises no select, no error and no tgt_we. A read of such an address returns 0000h.
- R3: A word access (req_byte=0) at an odd address raises acc_err in the same cycle. It also forces every select and tgt_we low.
- R4: A word access anywhere in the control-byte region raises acc_err, and no select or tgt_we is raised.
- R5: A byte access at an odd address in the wide-peripheral region raises acc_err, and no select or tgt_we is raised.
- R6: lane_en bit 0 is the even (low) byte and bit 1 is the odd (high) byte. A word access to the wide-peripheral, RAM or nonvolatile region drives 11. A byte access to the control, RAM or nonvolatile region drives 01 at an even address and 10 at an odd one. A byte access to the wide-peripheral region drives 01. A byte write places the byte on both halves of tgt_wdata. lane_en is 00 when no select is high.
- R7: An access to the narrow-peripheral region always drives lane_en=01. A word write there presents the low byte of the write data on tgt_wdata[7:0], so the high byte is not stored.
- R8: A read from the narrow-peripheral region returns the target byte in bits 7:0. Bits 15:8 are the fill value (00h by default) for a word read and 00h for a byte read.
- R9: A byte read from the wide-peripheral region returns the target's low byte, with the high byte zero.
- R10: A byte read from the control, RAM or nonvolatile region returns the addressed byte, zero-extended. The byte at an odd address is taken from the target's high lane.
- R11: A word read from the wide-peripheral, RAM or nonvolatile region returns the whole target word. The byte at the even address is placed in bits 7:0.
- R12: cpu_rdata is registered. It carries the result of a read one cycle after the request. After reset, and after any idle, write, rejected or unmapped cycle, it is 0000h.
- R13: tgt_we is high exactly when a valid write raises a select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0 for byte writes) |
| rgn_sel | output | 5 | One-hot region select |
| lane_en | output | 2 | Byte-lane enables toward the target |
| tgt_we | output | 1 | Write strobe toward the selected target |
| tgt_wdata | output | 16 | Lane-steered write data |
| acc_err | output | 1 | Illegal-access strobe, same cycle as the request |
| rd_sfr | input | 16 | Read word from the control-byte target |
| rd_p8 | input | 8 | Read byte from the narrow-peripheral target |
| rd_p16 | input | 16 | Read word from the wide-peripheral target |
| rd_ram | input | 16 | Read word from RAM |
| rd_nvm | input | 16 | Read word from nonvolatile memory |
| cpu_rdata | output | 16 | Formatted read data, one cycle after the request |

## Verification
The properties watch, on every cycle, the rules that follow from the request alone:
- at most one select is high, and none while idle;
- an error blocks every select and write;
- the three illegal-access cases always raise the error;
- the narrow region and byte accesses get the right lanes;
- the read bus is clear after an idle cycle.

Some behaviour only the bench's reference model can show, because it needs data stored by earlier writes:
- the values returned after a write;
- the little-endian byte placement;
- the zero and fill high bytes;
- dropping the high byte of a narrow-peripheral word write;
- the exact region edges, such as the last RAM word and the first nonvolatile byte.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;

  localparam int N_RGN = 5;
  localparam int SEL_SFR = 0;
  localparam int SEL_P8  = 1;
  localparam int SEL_P16 = 2;
  localparam int SEL_RAM = 3;
  localparam int SEL_NVM = 4;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_SFR  = 3'd1,
    RG_P8   = 3'd2,
    RG_P16  = 3'd3,
    RG_RAM  = 3'd4,
    RG_NVM  = 3'd5
  } region_e;

  // Region that owns a byte address; the gap between RAM and NVM maps to none.
  function automatic region_e map_region(input logic [15:0] a,
                                         input logic [15:0] sfr_end,
                                         input logic [15:0] p8_end,
                                         input logic [15:0] p16_end,
                                         input logic [15:0] ram_base,
                                         input logic [15:0] ram_last,
                                         input logic [15:0] nvm_base);
    if (a <= sfr_end)                       return RG_SFR;
    if (a <= p8_end)                        return RG_P8;
    if (a <= p16_end)                       return RG_P16;
    if (a >= ram_base && a <= ram_last)     return RG_RAM;
    if (a >= nvm_base)                      return RG_NVM;
    return RG_NONE;
  endfunction

  function automatic region_e region_of_index(input int idx);
    case (idx)
      SEL_SFR: return RG_SFR;
      SEL_P8:  return RG_P8;
      SEL_P16: return RG_P16;
      SEL_RAM: return RG_RAM;
      default: return RG_NVM;
    endcase
  endfunction

  function automatic int index_of_region(input region_e r);
    case (r)
      RG_SFR:  return SEL_SFR;
      RG_P8:   return SEL_P8;
      RG_P16:  return SEL_P16;
      RG_RAM:  return SEL_RAM;
      default: return SEL_NVM;
    endcase
  endfunction

  // Lane enable of a single byte: even address -> low lane.
  function automatic logic [1:0] byte_lane(input logic a0);
    return a0 ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [15:0] zext_byte(input logic [7:0] b);
    return {8'h00, b};
  endfunction

endpackage

// File: rtl/bus_region_map.sv
module bus_region_map
  import bus_dec_pkg::*;
#(
  parameter logic [15:0] SFR_END  = 16'h000F,
  parameter logic [15:0] P8_END   = 16'h00FF,
  parameter logic [15:0] P16_END  = 16'h01FF,
  parameter logic [15:0] RAM_BASE = 16'h0200,
  parameter logic [15:0] RAM_LAST = 16'h09FF,
  parameter logic [15:0] NVM_BASE = 16'h1100
) (
  input  logic        valid,
  input  logic        is_byte,
  input  logic [15:0] addr,
  output region_e     region,
  output logic        word_odd,
  output logic        sfr_word,
  output logic        p16_odd,
  output logic        err
);
  assign region   = map_region(addr, SFR_END, P8_END, P16_END, RAM_BASE, RAM_LAST, NVM_BASE);
  assign word_odd = valid && !is_byte && addr[0];
  assign sfr_word = valid && !is_byte && (region == RG_SFR);
  assign p16_odd  = valid && is_byte && addr[0] && (region == RG_P16);
  assign err      = word_odd || sfr_word || p16_odd;
endmodule

// File: rtl/bus_lane_steer.sv
module bus_lane_steer
  import bus_dec_pkg::*;
(
  input  logic             valid,
  input  logic             we,
  input  logic             is_byte,
  input  logic             addr0,
  input  logic             err,
  input  region_e          region,
  input  logic [15:0]      wdata,
  output logic [N_RGN-1:0] sel,
  output logic [1:0]       lanes,
  output logic             wr,
  output logic [15:0]      wdata_out
);
  logic accept;
  assign accept = valid && !err && (region != RG_NONE);

  for (genvar i = 0; i < N_RGN; i++) begin : g_sel
    assign sel[i] = accept && (region == region_of_index(i));
  end

  always_comb begin
    lanes = 2'b00;
    if (accept) begin
      if (region == RG_P8)        lanes = 2'b01;
      else if (!is_byte)          lanes = 2'b11;
      else                        lanes = byte_lane(addr0);
    end
  end

  assign wr        = accept && we;
  assign wdata_out = is_byte ? {wdata[7:0], wdata[7:0]} : wdata;
endmodule

// File: rtl/bus_rdata_fmt.sv
module bus_rdata_fmt
  import bus_dec_pkg::*;
#(
  parameter logic [7:0] P8_FILL = 8'h00
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  region_e               region,
  input  logic                  is_byte,
  input  logic                  addr0,
  input  logic [N_RGN-1:0][15:0] rd_words,
  output logic [15:0]           rdata
);
  logic [15:0] word;
  logic [15:0] shaped;

  assign word = rd_words[index_of_region(region)];

  always_comb begin
    case (region)
      RG_P8:   shaped = {(is_byte ? 8'h00 : P8_FILL), word[7:0]};
      RG_P16:  shaped = is_byte ? zext_byte(word[7:0]) : word;
      default: shaped = is_byte ? zext_byte(addr0 ? word[15:8] : word[7:0]) : word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= 16'h0000;
    else        rdata <= rd_en ? shaped : 16'h0000;
  end
endmodule

// File: rtl/bus_region_decoder.sv
module bus_region_decoder
  import bus_dec_pkg::*;
#(
  parameter logic [15:0] SFR_END  = 16'h000F,
  parameter logic [15:0] P8_END   = 16'h00FF,
  parameter logic [15:0] P16_END  = 16'h01FF,
  parameter logic [15:0] RAM_BASE = 16'h0200,
  parameter int          RAM_BYTES = 2048,
  parameter logic [15:0] NVM_BASE = 16'h1100,
  parameter logic [7:0]  P8_FILL  = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic             req_byte,
  input  logic [15:0]      req_addr,
  input  logic [15:0]      req_wdata,
  output logic [N_RGN-1:0] rgn_sel,
  output logic [1:0]       lane_en,
  output logic             tgt_we,
  output logic [15:0]      tgt_wdata,
  output logic             acc_err,
  input  logic [15:0]      rd_sfr,
  input  logic [7:0]       rd_p8,
  input  logic [15:0]      rd_p16,
  input  logic [15:0]      rd_ram,
  input  logic [15:0]      rd_nvm,
  output logic [15:0]      cpu_rdata
);
  localparam logic [15:0] RAM_LAST = 16'(RAM_BASE + RAM_BYTES - 1);

  // Named decode events, visible to the bound checker.
  region_e hit_region;
  logic    word_odd_ev;
  logic    sfr_word_ev;
  logic    p16_odd_ev;
  logic    read_ev;
  logic [N_RGN-1:0][15:0] rd_words;

  bus_region_map #(
    .SFR_END(SFR_END), .P8_END(P8_END), .P16_END(P16_END),
    .RAM_BASE(RAM_BASE), .RAM_LAST(RAM_LAST), .NVM_BASE(NVM_BASE)
  ) u_map (
    .valid(req_valid), .is_byte(req_byte), .addr(req_addr),
    .region(hit_region), .word_odd(word_odd_ev), .sfr_word(sfr_word_ev),
    .p16_odd(p16_odd_ev), .err(acc_err)
  );

  bus_lane_steer u_steer (
    .valid(req_valid), .we(req_we), .is_byte(req_byte), .addr0(req_addr[0]),
    .err(acc_err), .region(hit_region), .wdata(req_wdata),
    .sel(rgn_sel), .lanes(lane_en), .wr(tgt_we), .wdata_out(tgt_wdata)
  );

  assign rd_words[SEL_SFR] = rd_sfr;
  assign rd_words[SEL_P8]  = {8'h00, rd_p8};
  assign rd_words[SEL_P16] = rd_p16;
  assign rd_words[SEL_RAM] = rd_ram;
  assign rd_words[SEL_NVM] = rd_nvm;

  assign read_ev = (|rgn_sel) && !req_we;

  bus_rdata_fmt #(.P8_FILL(P8_FILL)) u_fmt (
    .clk(clk), .rst_n(rst_n), .rd_en(read_ev), .region(hit_region),
    .is_byte(req_byte), .addr0(req_addr[0]), .rd_words(rd_words), .rdata(cpu_rdata)
  );
endmodule

// File: rtl/bus_region_decoder_chk.sv
module bus_region_decoder_chk
  import bus_dec_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_we,
  input logic             req_byte,
  input logic [15:0]      req_addr,
  input logic [N_RGN-1:0] rgn_sel,
  input logic [1:0]       lane_en,
  input logic             tgt_we,
  input logic             acc_err,
  input logic [15:0]      cpu_rdata,
  input region_e          hit_region
);
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rgn_sel));

  p_sel_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (rgn_sel == '0));

  p_err_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (rgn_sel == '0 && !tgt_we));

  p_word_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_byte && req_addr[0]) |-> acc_err);

  p_sfr_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_byte && hit_region == RG_SFR) |-> acc_err);

  p_p16_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_byte && req_addr[0] && hit_region == RG_P16) |-> acc_err);

  p_byte_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_byte && (rgn_sel[SEL_SFR] || rgn_sel[SEL_RAM] || rgn_sel[SEL_NVM]))
      |-> (lane_en == (req_addr[0] ? 2'b10 : 2'b01)));

  p_p8_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_sel[SEL_P8] |-> (lane_en == 2'b01));

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (cpu_rdata == 16'h0000));

  p_we_r13: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_we |-> (req_we && rgn_sel != '0));
endmodule

bind bus_region_decoder bus_region_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_byte(req_byte), .req_addr(req_addr), .rgn_sel(rgn_sel),
  .lane_en(lane_en), .tgt_we(tgt_we), .acc_err(acc_err),
  .cpu_rdata(cpu_rdata), .hit_region(hit_region)
);

// File: tb/test_bus_region_decoder.sv
`timescale 1ns/1ps
module test_bus_region_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, req_byte = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [4:0]  rgn_sel;
  logic [1:0]  lane_en;
  logic        tgt_we, acc_err;
  logic [15:0] tgt_wdata, cpu_rdata;
  logic [15:0] rd_sfr = '0, rd_p16 = '0, rd_ram = '0, rd_nvm = '0;
  logic [7:0]  rd_p8 = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [15:0] exp_rd = 16'h0000;
  string       exp_rd_tag = "R12";

  logic [7:0] ref_mem [int];   // model built from the requirements
  logic [7:0] tgt_mem [int];   // target storage written through the DUT's outputs

  always #2 clk = ~clk;        // 250 MHz

  bus_region_decoder i_bus_region_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .rgn_sel(rgn_sel), .lane_en(lane_en), .tgt_we(tgt_we), .tgt_wdata(tgt_wdata),
    .acc_err(acc_err), .rd_sfr(rd_sfr), .rd_p8(rd_p8), .rd_p16(rd_p16),
    .rd_ram(rd_ram), .rd_nvm(rd_nvm), .cpu_rdata(cpu_rdata)
  );

  function automatic logic [7:0] ref_b(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] tgt_b(input int a);
    return tgt_mem.exists(a) ? tgt_mem[a] : 8'h00;
  endfunction

  // 0 none, 1 control, 2 narrow, 3 wide, 4 RAM, 5 NVM
  function automatic int ref_region(input int a);
    if (a < 16)                   return 1;
    if (a < 256)                  return 2;
    if (a < 512)                  return 3;
    if (a < 512 + 2048)           return 4;
    if (a >= 4352)                return 5;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic access(input bit v, input bit we, input bit bt,
                        input logic [15:0] a, input logic [15:0] w);
    int rg, base;
    bit e_err, e_ok;
    logic [4:0]  e_sel;
    logic [1:0]  e_lane;
    logic [15:0] e_wd, nxt_rd;
    string tag;
    @(negedge clk);
    // registered read result of the previous request (R12 and R8..R11)
    chk(cpu_rdata === exp_rd, exp_rd_tag, {16'h0, cpu_rdata}, {16'h0, exp_rd});
    req_valid = v; req_we = we; req_byte = bt; req_addr = a; req_wdata = w;
    base = {a[15:1], 1'b0};
    rd_sfr = {tgt_b(base + 1), tgt_b(base)};
    rd_p16 = rd_sfr; rd_ram = rd_sfr; rd_nvm = rd_sfr;
    rd_p8  = tgt_b(a);
    #1;
    rg    = ref_region(a);
    e_err = v && ((!bt && a[0]) || (!bt && rg == 1) || (bt && a[0] && rg == 3));
    e_ok  = v && !e_err && rg != 0;
    e_sel = e_ok ? 5'(1 << (rg - 1)) : 5'b0;
    if (!e_ok)         e_lane = 2'b00;
    else if (rg == 2)  e_lane = 2'b01;
    else if (!bt)      e_lane = 2'b11;
    else               e_lane = a[0] ? 2'b10 : 2'b01;
    e_wd = bt ? {w[7:0], w[7:0]} : w;

    if (!bt && a[0])        tag = "R3";
    else if (!bt && rg == 1) tag = "R4";
    else if (bt && a[0] && rg == 3) tag = "R5";
    else                    tag = "R1";
    chk(acc_err === e_err, tag, {31'h0, acc_err}, {31'h0, e_err});
    chk(rgn_sel === e_sel, (rg == 0) ? "R2" : tag, {27'h0, rgn_sel}, {27'h0, e_sel});
    chk(lane_en === e_lane, (rg == 2) ? "R7" : "R6", {30'h0, lane_en}, {30'h0, e_lane});
    chk(tgt_we === (e_ok && we), "R13", {31'h0, tgt_we}, {31'h0, (e_ok && we)});
    if (e_ok && we)
      chk(tgt_wdata[7:0] === e_wd[7:0] && (rg == 2 || tgt_wdata === e_wd),
          (rg == 2) ? "R7" : "R6", {16'h0, tgt_wdata}, {16'h0, e_wd});

    // expected read result, one cycle later
    nxt_rd = 16'h0000;
    exp_rd_tag = "R12";
    if (e_ok && !we) begin
      if (rg == 2) begin
        nxt_rd = {8'h00, ref_b(a)}; exp_rd_tag = "R8";
      end else if (bt) begin
        nxt_rd = {8'h00, ref_b(a)}; exp_rd_tag = (rg == 3) ? "R9" : "R10";
      end else begin
        nxt_rd = {ref_b(a + 1), ref_b(a)}; exp_rd_tag = "R11";
      end
    end else if (v && !we && rg == 0) exp_rd_tag = "R2";
    exp_rd = nxt_rd;

    // reference write
    if (e_ok && we) begin
      ref_mem[a] = w[7:0];
      if (!bt && rg != 2) ref_mem[a + 1] = w[15:8];
    end
    // target write through the DUT's lanes
    if (tgt_we) begin
      if (rgn_sel[1]) tgt_mem[a] = tgt_wdata[7:0];
      else begin
        if (lane_en[0]) tgt_mem[base]     = tgt_wdata[7:0];
        if (lane_en[1]) tgt_mem[base + 1] = tgt_wdata[15:8];
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cpu_rdata === 16'h0000 && rgn_sel === 5'b0, "R12", {16'h0, cpu_rdata}, 32'h0);
    rst_n = 1'b1;
    // control bytes: byte write/read both lanes, word access rejected (R4)
    access(1, 1, 1, 16'h0003, 16'hFF5A);
    access(1, 0, 1, 16'h0003, 16'h0000);   // R10 odd byte from high lane
    access(1, 0, 1, 16'h0002, 16'h0000);
    access(1, 0, 0, 16'h0002, 16'h0000);   // R4
    access(1, 1, 0, 16'h000E, 16'h1111);   // R4
    // narrow peripherals: high byte dropped (R7), fill on word read (R8)
    access(1, 1, 0, 16'h0020, 16'h1234);
    access(1, 0, 1, 16'h0020, 16'h0000);
    access(1, 0, 1, 16'h0021, 16'h0000);
    access(1, 0, 0, 16'h0020, 16'h0000);
    access(1, 1, 1, 16'h00FF, 16'h00C3);
    access(1, 0, 1, 16'h00FF, 16'h0000);
    // wide peripherals (R5, R9, R11)
    access(1, 1, 0, 16'h0102, 16'hBEEF);
    access(1, 0, 1, 16'h0102, 16'h0000);
    access(1, 0, 1, 16'h0103, 16'h0000);   // R5
    access(1, 0, 0, 16'h0102, 16'h0000);
    access(1, 1, 1, 16'h01FE, 16'h0099);
    access(1, 0, 0, 16'h01FE, 16'h0000);
    // RAM: little-endian placement (R10, R11), odd word rejected (R3)
    access(1, 1, 1, 16'h0205, 16'h0077);
    access(1, 0, 0, 16'h0204, 16'h0000);
    access(1, 0, 1, 16'h0205, 16'h0000);
    access(1, 1, 0, 16'h0207, 16'hDEAD);   // R3
    access(1, 1, 0, 16'h09FE, 16'hCAFE);   // last RAM word
    access(1, 0, 1, 16'h09FF, 16'h0000);
    // gap and NVM edges (R2)
    access(1, 1, 0, 16'h0A00, 16'h5555);
    access(1, 0, 0, 16'h0A00, 16'h0000);
    access(1, 0, 1, 16'h10FF, 16'h0000);
    access(1, 1, 1, 16'h1100, 16'h00AB);
    access(1, 0, 0, 16'h1100, 16'h0000);
    access(1, 1, 0, 16'hFFFE, 16'h8001);
    access(1, 0, 0, 16'hFFFE, 16'h0000);
    access(1, 0, 1, 16'hFFFF, 16'h0000);
    // idle and write cycles leave the read bus clear (R12)
    access(0, 0, 0, 16'h0204, 16'h0000);
    access(1, 1, 0, 16'h0204, 16'h4321);
    access(0, 1, 1, 16'h0000, 16'h0000);
    // mixed traffic around the region edges
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      case ($urandom_range(0, 6))
        0: a = 16'($urandom_range(0, 15));
        1: a = 16'($urandom_range(16, 47));
        2: a = 16'($urandom_range(250, 270));
        3: a = 16'($urandom_range(500, 530));
        4: a = 16'($urandom_range(2550, 2570));
        5: a = 16'($urandom_range(4345, 4360));
        default: a = 16'($urandom_range(65500, 65535));
      endcase
      access(1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), a, 16'($urandom));
    end
    access(0, 0, 0, 16'h0000, 16'h0000);
    access(0, 0, 0, 16'h0000, 16'h0000);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule